// File: doc/BRIEF.md
# Packet-Aware Stream Pattern Checker

This block drains a receive FIFO of 32-bit words and checks every word against an expected test pattern. All words of one packet carry the same value, and that value rises by one from each packet to the next. The packet length in words is set at run time through `pkt_len`. The checker consumes one word in every cycle in which the FIFO reports data. This follows the FIFO's usual read-enable and empty convention: the read request acts as the ready signal and `!fifo_empty` acts as the valid signal. The block never holds the FIFO back. The word is returned on the cycle after the request.

Each mismatch falls into one of two kinds:

- **Drop.** The first word of a packet is wrong, which means one or more whole packets are missing. The checker reports a drop and resynchronises: it takes the received word as the expected value for the rest of that packet, so counting continues from the new position.
- **Corruption.** A later word inside a packet is wrong. The checker reports a corruption and keeps its expected value unchanged.

Each kind has a one-cycle event pulse, a sticky flag and a saturating counter. An error LED blinks while either sticky flag is set. A clear input resets the flags and the counters.

Top module: `pkt_stream_checker`

## Requirements
- R1: `fifo_rd_en` is high in exactly those cycles after reset release in which `fifo_empty` is low. It is low while `rst_n` is low and during the first cycle after reset release.
- R2: A word is taken from `fifo_rd_data` on the cycle after the read request for it. Its result shows on `drop_evt` / `corrupt_evt` as a one-cycle pulse in the cycle after that. When a word matches, neither pulse is raised.
- R3: After reset the expected value is `INIT_VALUE` (default 0). It stays the same for every word of a packet and increases by 1, modulo 2^32, after the last word of the packet.
- R4: A mismatch on the first word of a packet pulses `drop_evt`. The received word then becomes the expected value for the rest of that packet, and the next packet expects that word plus 1.
- R5: A mismatch on any later word of a packet pulses `corrupt_evt` and leaves the expected value unchanged, including when the mismatch is on the last word.
- R6: The packet length is read from `pkt_len` when a packet's first word is taken. A change made part-way through a packet takes effect at the next packet. The lengths 365, 2240 and 1 are supported.
- R7: `drop_cnt` and `corrupt_cnt` rise by 1 on the cycle after each matching event pulse. They stop at all-ones.
- R8: When `clr` is high at a clock edge, both counters and both sticky flags are zero after that edge. `clr` takes priority over an event counted on the same edge.
- R9: `drop_seen` / `corrupt_seen` go high on the cycle after the matching event pulse and stay high until `clr`.
- R10: `err_led` stays low while both sticky flags are low. While either flag is high, `err_led` is a square wave with a period of 2^(BLINK_BIT+1) cycles and a 50% duty cycle.
- R11: While in reset, both event pulses, both flags, both counters and `err_led` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clears the counters and the sticky flags |
| pkt_len | input | LEN_W | Packet length in words, must be nonzero |
| fifo_empty | input | 1 | FIFO has no data |
| fifo_rd_en | output | 1 | FIFO read request |
| fifo_rd_data | input | DATA_W | FIFO read data, valid one cycle after the request |
| drop_evt | output | 1 | Pulse: first word of a packet was wrong |
| corrupt_evt | output | 1 | Pulse: a later word of a packet was wrong |
| drop_seen | output | 1 | Sticky drop flag |
| corrupt_seen | output | 1 | Sticky corruption flag |
| drop_cnt | output | CNT_W | Saturating drop count |
| corrupt_cnt | output | CNT_W | Saturating corruption count |
| err_led | output | 1 | Blinking error indicator |

## Verification
The properties assume two things about the inputs:

- `pkt_len` is never zero while a read is under way.
- The FIFO presents the requested word exactly one cycle after `fifo_rd_en`, so the event timing can be tied to the read two cycles earlier.

The stimulus is built to stay inside these assumptions:

- The FIFO model pops only on a granted read and drives the popped word with the next edge.
- `pkt_len` is always set to 1, 365 or 2240.
- `pkt_len` is changed only once the FIFO and the check pipeline have drained.

Under these conditions the length that the bench's reference model applies to a packet is the same length the block latches.

// File: rtl/psc_pkg.sv
package psc_pkg;
  // Outcome of checking one consumed word.
  typedef enum logic [1:0] {
    VERD_OK      = 2'd0,
    VERD_DROP    = 2'd1,
    VERD_CORRUPT = 2'd2
  } verdict_e;

  // Index of each error kind in per-kind arrays.
  localparam int unsigned KIND_DROP    = 0;
  localparam int unsigned KIND_CORRUPT = 1;
  localparam int unsigned KIND_N       = 2;
endpackage

// File: rtl/psc_read_stage.sv
// Reads the FIFO whenever it holds data and marks the returned word one cycle later.
module psc_read_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  output logic              fifo_rd_en,
  input  logic [DATA_W-1:0] fifo_rd_data,
  output logic              word_vld,
  output logic [DATA_W-1:0] word_data
);
  logic armed_q;

  // armed_q holds off reads for the first cycle after reset release.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      word_vld <= 1'b0;
    end else begin
      armed_q  <= 1'b1;
      word_vld <= fifo_rd_en;
    end
  end

  assign fifo_rd_en = armed_q & ~fifo_empty;
  assign word_data  = fifo_rd_data;
endmodule

// File: rtl/psc_pattern_track.sv
// Tracks the expected value and the position in the packet, and classifies each word.
module psc_pattern_track
  import psc_pkg::*;
#(
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       LEN_W      = 12,
  parameter logic [DATA_W-1:0] INIT_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] word_data,
  input  logic [LEN_W-1:0]  pkt_len,
  output verdict_e          verdict
);
  logic [DATA_W-1:0] exp_q;
  logic [LEN_W-1:0]  idx_q;
  logic [LEN_W-1:0]  len_q;

  logic              first_w;
  logic              last_w;
  logic              mism_w;
  logic [LEN_W-1:0]  len_eff;
  logic [DATA_W-1:0] base_w;

  always_comb begin
    first_w = (idx_q == '0);
    // The first word reads the live length; later words use the latched one.
    len_eff = first_w ? pkt_len : len_q;
    last_w  = (idx_q == len_eff - LEN_W'(1));
    mism_w  = (word_data != exp_q);
    // On a first word the received value becomes the reference, which resyncs after a drop.
    base_w  = first_w ? word_data : exp_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q   <= INIT_VALUE;
      idx_q   <= '0;
      len_q   <= '0;
      verdict <= VERD_OK;
    end else if (word_vld) begin
      if (first_w) len_q <= pkt_len;
      if (last_w) begin
        exp_q <= base_w + DATA_W'(1);
        idx_q <= '0;
      end else begin
        exp_q <= base_w;
        idx_q <= idx_q + LEN_W'(1);
      end
      if (!mism_w)      verdict <= VERD_OK;
      else if (first_w) verdict <= VERD_DROP;
      else              verdict <= VERD_CORRUPT;
    end else begin
      verdict <= VERD_OK;
    end
  end
endmodule

// File: rtl/psc_sat_counter.sv
// Event counter that stops at all-ones; clear takes priority.
module psc_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clr)              count <= '0;
    else if (inc && (count != MAX)) count <= count + W'(1);
  end
endmodule

// File: rtl/psc_err_indicator.sv
// Sticky error flags and a blinking LED gated by them.
module psc_err_indicator #(
  parameter int unsigned BLINK_BIT = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic drop_evt,
  input  logic corrupt_evt,
  output logic drop_seen,
  output logic corrupt_seen,
  output logic err_led
);
  localparam int unsigned DIV_W = BLINK_BIT + 1;

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      drop_seen    <= 1'b0;
      corrupt_seen <= 1'b0;
    end else begin
      drop_seen    <= drop_seen | drop_evt;
      corrupt_seen <= corrupt_seen | corrupt_evt;
    end
  end

  assign err_led = (drop_seen | corrupt_seen) & div_q[BLINK_BIT];
endmodule

// File: rtl/pkt_stream_checker.sv
module pkt_stream_checker
  import psc_pkg::*;
#(
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       LEN_W      = 12,
  parameter int unsigned       CNT_W      = 16,
  parameter int unsigned       BLINK_BIT  = 24,
  parameter logic [DATA_W-1:0] INIT_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              fifo_empty,
  output logic              fifo_rd_en,
  input  logic [DATA_W-1:0] fifo_rd_data,
  output logic              drop_evt,
  output logic              corrupt_evt,
  output logic              drop_seen,
  output logic              corrupt_seen,
  output logic [CNT_W-1:0]  drop_cnt,
  output logic [CNT_W-1:0]  corrupt_cnt,
  output logic              err_led
);
  logic              word_vld;
  logic [DATA_W-1:0] word_data;
  verdict_e          verdict;
  logic [KIND_N-1:0] evt_vec;
  logic [CNT_W-1:0]  cnt_arr [KIND_N];

  psc_read_stage #(.DATA_W(DATA_W)) u_read (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_empty   (fifo_empty),
    .fifo_rd_en   (fifo_rd_en),
    .fifo_rd_data (fifo_rd_data),
    .word_vld     (word_vld),
    .word_data    (word_data)
  );

  psc_pattern_track #(
    .DATA_W     (DATA_W),
    .LEN_W      (LEN_W),
    .INIT_VALUE (INIT_VALUE)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_vld  (word_vld),
    .word_data (word_data),
    .pkt_len   (pkt_len),
    .verdict   (verdict)
  );

  assign drop_evt    = (verdict == VERD_DROP);
  assign corrupt_evt = (verdict == VERD_CORRUPT);

  assign evt_vec[KIND_DROP]    = drop_evt;
  assign evt_vec[KIND_CORRUPT] = corrupt_evt;

  // One saturating counter per error kind.
  for (genvar g = 0; g < KIND_N; g++) begin : g_cnt
    psc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (evt_vec[g]),
      .count (cnt_arr[g])
    );
  end

  assign drop_cnt    = cnt_arr[KIND_DROP];
  assign corrupt_cnt = cnt_arr[KIND_CORRUPT];

  psc_err_indicator #(.BLINK_BIT(BLINK_BIT)) u_ind (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .drop_evt     (drop_evt),
    .corrupt_evt  (corrupt_evt),
    .drop_seen    (drop_seen),
    .corrupt_seen (corrupt_seen),
    .err_led      (err_led)
  );
endmodule

// File: rtl/psc_props.sv
module psc_props #(
  parameter int unsigned LEN_W = 12,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic [LEN_W-1:0] pkt_len,
  input logic             fifo_empty,
  input logic             fifo_rd_en,
  input logic             drop_evt,
  input logic             corrupt_evt,
  input logic             drop_seen,
  input logic             corrupt_seen,
  input logic [CNT_W-1:0] drop_cnt,
  input logic [CNT_W-1:0] corrupt_cnt,
  input logic             err_led
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  p_read_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> !fifo_empty);

  p_evt_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt || corrupt_evt) |-> $past(fifo_rd_en, 2));

  p_evt_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(drop_evt && corrupt_evt));

  // Input assumption: a usable packet length whenever a word is requested.
  p_len_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> (pkt_len != '0));

  p_drop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !clr && drop_cnt != MAX) |=> drop_cnt == $past(drop_cnt) + CNT_W'(1));

  p_corrupt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (corrupt_evt && !clr && corrupt_cnt != MAX) |=> corrupt_cnt == $past(corrupt_cnt) + CNT_W'(1));

  p_drop_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == MAX && !clr) |=> drop_cnt == MAX);

  p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (drop_cnt == '0 && corrupt_cnt == '0 && !drop_seen && !corrupt_seen));

  p_drop_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_seen && !clr) |=> drop_seen);

  p_corrupt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (corrupt_seen && !clr) |=> corrupt_seen);

  p_led_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(drop_seen || corrupt_seen) |-> !err_led);
endmodule

bind pkt_stream_checker psc_props #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_psc_props (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr          (clr),
  .pkt_len      (pkt_len),
  .fifo_empty   (fifo_empty),
  .fifo_rd_en   (fifo_rd_en),
  .drop_evt     (drop_evt),
  .corrupt_evt  (corrupt_evt),
  .drop_seen    (drop_seen),
  .corrupt_seen (corrupt_seen),
  .drop_cnt     (drop_cnt),
  .corrupt_cnt  (corrupt_cnt),
  .err_led      (err_led)
);

// File: tb/pkt_stream_checker_tb_top.sv
module pkt_stream_checker_tb_top;
  localparam int DATA_W    = 32;
  localparam int LEN_W     = 12;
  localparam int CNT_W     = 4;
  localparam int BLINK_BIT = 3;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clr = 1'b0;
  logic [LEN_W-1:0]  pkt_len = LEN_W'(365);
  logic              fifo_empty = 1'b1;
  logic              fifo_rd_en;
  logic [DATA_W-1:0] fifo_rd_data = '0;
  logic              drop_evt, corrupt_evt, drop_seen, corrupt_seen, err_led;
  logic [CNT_W-1:0]  drop_cnt, corrupt_cnt;

  always #4 clk = ~clk;  // 125 MHz

  pkt_stream_checker #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .BLINK_BIT(BLINK_BIT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .pkt_len(pkt_len),
    .fifo_empty(fifo_empty), .fifo_rd_en(fifo_rd_en), .fifo_rd_data(fifo_rd_data),
    .drop_evt(drop_evt), .corrupt_evt(corrupt_evt),
    .drop_seen(drop_seen), .corrupt_seen(corrupt_seen),
    .drop_cnt(drop_cnt), .corrupt_cnt(corrupt_cnt), .err_led(err_led)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DATA_W-1:0] incoming_q[$];
  logic [DATA_W-1:0] words_q[$];
  int                kind_q[$];   // 0 ok, 1 drop, 2 corrupt

  // Reference model state, driven by the requirements.
  logic [DATA_W-1:0] m_exp = '0;
  int m_idx = 0;
  int m_len = 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // FIFO model: pop on a granted read, result appears after the edge.
  always @(posedge clk) begin
    if (fifo_rd_en && words_q.size() > 0) fifo_rd_data <= words_q.pop_front();
    while (incoming_q.size() > 0) words_q.push_back(incoming_q.pop_front());
    fifo_empty <= (words_q.size() == 0);
  end

  // Driver: model the expected outcome, then push the word.
  task automatic push_word(input logic [DATA_W-1:0] w);
    int k;
    logic [DATA_W-1:0] base;
    if (m_idx == 0) begin
      m_len = int'(pkt_len);
      k = (w != m_exp) ? 1 : 0;
      base = w;
    end else begin
      k = (w != m_exp) ? 2 : 0;
      base = m_exp;
    end
    if (m_idx == m_len - 1) begin
      m_exp = base + 1;
      m_idx = 0;
    end else begin
      m_exp = base;
      m_idx++;
    end
    kind_q.push_back(k);
    @(negedge clk);
    incoming_q.push_back(w);
  endtask

  task automatic send_pkt(input logic [DATA_W-1:0] v, input int len,
                          input int bad_idx, input logic [DATA_W-1:0] bad_v);
    for (int i = 0; i < len; i++) push_word((i == bad_idx) ? bad_v : v);
  endtask

  task automatic wait_idle();
    do @(negedge clk);
    while (incoming_q.size() != 0 || words_q.size() != 0 || !fifo_empty);
    repeat (4) @(negedge clk);
  endtask

  // Monitor: every read is due on the second falling edge after it was requested.
  bit pipe0 = 0;
  bit pipe1 = 0;
  always @(negedge clk) begin
    bit due;
    int k;
    if (rst_n && !done) begin
      due = pipe1;
      pipe1 = pipe0;
      pipe0 = fifo_rd_en;
      check(fifo_rd_en == !fifo_empty, "R1", "read enable vs not-empty",
            longint'(fifo_rd_en), longint'(!fifo_empty));
      if (due) begin
        k = (kind_q.size() > 0) ? kind_q.pop_front() : -1;
        check(drop_evt == (k == 1), (k == 1) ? "R4" : "R2", "drop pulse",
              longint'(drop_evt), longint'(k == 1));
        check(corrupt_evt == (k == 2), (k == 2) ? "R5" : "R3", "corrupt pulse",
              longint'(corrupt_evt), longint'(k == 2));
      end else begin
        check(!drop_evt && !corrupt_evt, "R2", "pulse without word",
              longint'({drop_evt, corrupt_evt}), 0);
      end
    end
  end

  initial begin
    int highs;
    bit seen0, seen1;
    repeat (5) @(negedge clk);
    // R11: reset state
    check(!fifo_rd_en, "R11", "rd_en in reset", longint'(fifo_rd_en), 0);
    check(drop_cnt == 0 && corrupt_cnt == 0, "R11", "counters in reset",
          longint'({drop_cnt, corrupt_cnt}), 0);
    check(!drop_seen && !corrupt_seen && !err_led && !drop_evt && !corrupt_evt,
          "R11", "flags/led in reset",
          longint'({drop_seen, corrupt_seen, err_led, drop_evt, corrupt_evt}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: clean ramp of 365-word packets
    send_pkt(0, 365, -1, 0);
    send_pkt(1, 365, -1, 0);
    send_pkt(2, 365, -1, 0);
    wait_idle();
    check(drop_cnt == 0 && corrupt_cnt == 0, "R3", "no errors on clean ramp",
          longint'({drop_cnt, corrupt_cnt}), 0);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      highs += int'(err_led);
    end
    check(highs == 0, "R10", "led dark without errors", highs, 0);

    // R4: missing packets 3..6, then resync
    send_pkt(7, 365, -1, 0);
    send_pkt(8, 365, -1, 0);
    wait_idle();
    check(drop_cnt == 1, "R4", "drop count after gap", longint'(drop_cnt), 1);
    check(drop_seen && !corrupt_seen, "R9", "drop flag only",
          longint'({drop_seen, corrupt_seen}), 2);

    // R5: corruption mid-packet and on the last word
    send_pkt(9, 365, 100, 32'hDEAD_BEEF);
    send_pkt(10, 365, 364, 32'h0);
    send_pkt(11, 365, -1, 0);
    wait_idle();
    check(corrupt_cnt == 2, "R5", "corrupt count", longint'(corrupt_cnt), 2);
    check(drop_cnt == 1, "R5", "no drop from corruption", longint'(drop_cnt), 1);
    check(corrupt_seen, "R9", "corrupt flag", longint'(corrupt_seen), 1);

    // R10: blink shape
    highs = 0; seen0 = 0; seen1 = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      highs += int'(err_led);
      if (err_led) seen1 = 1; else seen0 = 1;
    end
    check(highs == 16, "R10", "led high cycles in 32", highs, 16);
    check(seen0 && seen1, "R10", "led toggles", longint'({seen0, seen1}), 3);

    // R6: long packets and a length change mid-packet
    pkt_len = LEN_W'(2240);
    send_pkt(12, 2240, -1, 0);
    for (int i = 0; i < 10; i++) push_word(13);
    wait_idle();
    pkt_len = LEN_W'(365);
    for (int i = 0; i < 2230; i++) push_word(13);
    send_pkt(14, 365, -1, 0);
    send_pkt(15, 365, -1, 0);
    wait_idle();
    check(drop_cnt == 1 && corrupt_cnt == 2, "R6", "no errors across length change",
          longint'({drop_cnt, corrupt_cnt}), longint'({4'd1, 4'd2}));

    // R8: clear
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(drop_cnt == 0 && corrupt_cnt == 0, "R8", "counters cleared",
          longint'({drop_cnt, corrupt_cnt}), 0);
    check(!drop_seen && !corrupt_seen && !err_led, "R8", "flags and led cleared",
          longint'({drop_seen, corrupt_seen, err_led}), 0);

    // R7: saturation with one-word packets
    pkt_len = LEN_W'(1);
    @(negedge clk);
    for (int i = 0; i < 20; i++) push_word(m_exp + 3);
    wait_idle();
    check(drop_cnt == CMAX, "R7", "drop count saturates", longint'(drop_cnt), longint'(CMAX));
    check(corrupt_cnt == 0, "R7", "corrupt count untouched", longint'(corrupt_cnt), 0);
    for (int i = 0; i < 8; i++) push_word(m_exp);
    wait_idle();
    check(drop_cnt == CMAX, "R7", "saturated count holds", longint'(drop_cnt), longint'(CMAX));
    check(drop_seen, "R9", "drop flag after saturation", longint'(drop_seen), 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule